// File: doc/BRIEF.md
# Guard-Banded Transmit Credit Gate

This block decides, cycle by cycle, whether user logic may launch its next transaction-layer packet toward a PCIe-style transmit path. It keeps flow-control credit for three traffic classes (posted, non-posted, completion), each with a header pool and a data pool. The partner's advertised credit is loaded on an update strobe. Each grant is then charged against the loaded value. A class is allowed to send only while the charge leaves a fixed safety margin untouched. The block never uses any consumed-credit count reported back by the transmit core.

A static mode input selects how non-posted header credit is judged. In guard mode the non-posted header pool is margin-checked like the others. In count mode the header pool is bypassed. A non-posted request then goes out only while the number of outstanding non-posted requests is below the non-posted header credit latched at the last update. A done pulse retires one outstanding request. Requests arrive as a 3-bit vector with a per-class data cost. The grant is combinational in the same cycle, and at most one class is granted per cycle.

Top module: `txcred_gate`

## Requirements
- R1: After reset no class is granted, even with all requests high, until an update strobe loads credit, and the outstanding count reads 0.
- R2: On a cycle with `adv_upd` high each header and data pool loads its advertised input. A grant charges 1 header credit and the class's data cost (4-dword units) to that class, and the charge is visible from the next cycle.
- R3: A pool whose advertised value was 128 or more when loaded is guarded. A guarded header pool grants only while its credit is at least 1 + 64. A guarded data pool grants only while its credit is at least cost + 128.
- R4: A pool whose advertised value was below 128 has no margin. The header pool needs at least 1 credit and the data pool needs at least the cost.
- R5: With `cnt_mode` high the non-posted header pool is not consulted. A non-posted request is granted only while the outstanding count is below the non-posted header value latched at the last update. Its data pool is still checked per R3/R4.
- R6: The outstanding count goes up by 1 on a non-posted grant unless it is at its maximum (255). It goes down by 1 on `np_done` unless it is 0. When both take effect in the same cycle it holds.
- R7: Among classes that are requesting and covered by credit, completion (bit 2) wins over posted (bit 0), which wins over non-posted (bit 1). `gnt` has at most one bit set, and only for a requesting class.
- R8: When an update coincides with a grant, the granted class's pools load the advertised value minus that grant's cost, floored at 0.
- R9: `gnt` follows `req`, the costs and the current credit in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_mode | input | 1 | Static: 0 guard mode, 1 outstanding-count mode for non-posted headers |
| adv_upd | input | 1 | Strobe that loads the advertised credit inputs |
| adv_hdr_p | input | 8 | Advertised posted header credit |
| adv_dat_p | input | 12 | Advertised posted data credit |
| adv_hdr_np | input | 8 | Advertised non-posted header credit |
| adv_dat_np | input | 12 | Advertised non-posted data credit |
| adv_hdr_cpl | input | 8 | Advertised completion header credit |
| adv_dat_cpl | input | 12 | Advertised completion data credit |
| req | input | 3 | Request: bit0 posted, bit1 non-posted, bit2 completion |
| dcost_p | input | 9 | Posted packet data cost |
| dcost_np | input | 9 | Non-posted packet data cost |
| dcost_cpl | input | 9 | Completion packet data cost |
| np_done | input | 1 | One non-posted request has completed |
| gnt | output | 3 | Grant, same bit order as req |
| np_outstanding | output | 8 | Outstanding non-posted request count |

## Verification
Two pairs of functions can fall in the same cycle. An update strobe can coincide with a grant to the same class. A non-posted grant can coincide with a done pulse. Directed sequences force both: an update lands while a completion is granted, and the later count of grants must match the loaded value less that grant. A done pulse lands while a non-posted grant is issued, and the outstanding count must hold. Random traffic also produces both collisions often, and every cycle is judged against a bench model built from the requirements.

// File: rtl/txcred_gate.sv
module txcred_gate #(
  parameter int HW  = 8,
  parameter int DW  = 12,
  parameter int CW  = 9,
  parameter int HGB = 64,
  parameter int DGB = 128,
  parameter int GTH = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_mode,
  input  logic          adv_upd,
  input  logic [HW-1:0] adv_hdr_p,
  input  logic [DW-1:0] adv_dat_p,
  input  logic [HW-1:0] adv_hdr_np,
  input  logic [DW-1:0] adv_dat_np,
  input  logic [HW-1:0] adv_hdr_cpl,
  input  logic [DW-1:0] adv_dat_cpl,
  input  logic [2:0]    req,
  input  logic [CW-1:0] dcost_p,
  input  logic [CW-1:0] dcost_np,
  input  logic [CW-1:0] dcost_cpl,
  input  logic          np_done,
  output logic [2:0]    gnt,
  output logic [HW-1:0] np_outstanding
);
  localparam int NC = 3;
  localparam logic [HW-1:0] OMAX = '1;

  logic [HW-1:0] advh [NC];
  logic [DW-1:0] advd [NC];
  logic [CW-1:0] dc   [NC];
  logic [HW-1:0] ah   [NC];
  logic [DW-1:0] ad   [NC];
  logic [NC-1:0] gh, gd, ok;
  logic [HW-1:0] nph_init, outst;

  assign advh = '{adv_hdr_p, adv_hdr_np, adv_hdr_cpl};
  assign advd = '{adv_dat_p, adv_dat_np, adv_dat_cpl};
  assign dc   = '{dcost_p, dcost_np, dcost_cpl};

  function automatic logic [HW-1:0] hsub(input logic [HW-1:0] a, input logic b);
    return (b && a != '0) ? a - 1'b1 : a;
  endfunction

  function automatic logic [DW-1:0] dsub(input logic [DW-1:0] a, input logic [CW-1:0] c);
    return ({1'b0, a} >= (DW+1)'(c)) ? a - DW'(c) : '0;
  endfunction

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      logic [HW:0] hneed;
      logic [DW:0] dneed;
      logic        hok;
      hneed = (HW+1)'(1) + (gh[i] ? (HW+1)'(HGB) : '0);
      dneed = (DW+1)'(dc[i]) + (gd[i] ? (DW+1)'(DGB) : '0);
      hok   = {1'b0, ah[i]} >= hneed;
      if (i == 1 && cnt_mode) hok = outst < nph_init;
      ok[i] = req[i] && hok && ({1'b0, ad[i]} >= dneed);
    end
  end

  assign gnt = ok[2] ? 3'b100 : ok[0] ? 3'b001 : ok[1] ? 3'b010 : 3'b000;
  assign np_outstanding = outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin
        ah[i] <= '0;
        ad[i] <= '0;
      end
      gh <= '0;
      gd <= '0;
      nph_init <= '0;
    end else begin
      for (int i = 0; i < NC; i++) begin
        if (adv_upd) begin
          ah[i] <= hsub(advh[i], gnt[i]);
          ad[i] <= dsub(advd[i], gnt[i] ? dc[i] : '0);
          gh[i] <= {1'b0, advh[i]} >= (HW+1)'(GTH);
          gd[i] <= {1'b0, advd[i]} >= (DW+1)'(GTH);
        end else if (gnt[i]) begin
          ah[i] <= hsub(ah[i], 1'b1);
          ad[i] <= dsub(ad[i], dc[i]);
        end
      end
      if (adv_upd) nph_init <= adv_hdr_np;
    end
  end

  wire up = gnt[1] && outst != OMAX;
  wire dn = np_done && outst != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          outst <= '0;
    else if (up && !dn)  outst <= outst + 1'b1;
    else if (dn && !up)  outst <= outst - 1'b1;
  end

  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == 3'b000));

  p_hdr_charge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[0] && !adv_upd |=> ah[0] == $past(ah[0]) - 1'b1);

  p_upd_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv_upd && !gnt[2] |=> ah[2] == $past(adv_hdr_cpl));

  p_np_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_mode && gnt[1] |-> outst < nph_init);

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outst == '0 && !gnt[1] |=> outst == '0);
endmodule

// File: tb/txcred_gate_tb.sv
module txcred_gate_tb;
  logic clk = 0, rst_n = 0, cnt_mode = 0, adv_upd = 0, np_done = 0;
  logic [7:0]  ahp = 0, ahn = 0, ahc = 0;
  logic [11:0] adp = 0, adn = 0, adc = 0;
  logic [2:0]  req = 0;
  logic [8:0]  cp = 0, cn = 0, cc = 0;
  logic [2:0]  gnt;
  logic [7:0]  outst;

  int n_chk = 0, n_bad = 0, ng;
  bit fin = 0;
  logic [2:0] lastg;
  int mah[3], mad[3], minit, mout;
  bit mgh[3], mgd[3];

  always #5 clk = ~clk;

  txcred_gate u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_mode(cnt_mode), .adv_upd(adv_upd),
    .adv_hdr_p(ahp), .adv_dat_p(adp), .adv_hdr_np(ahn), .adv_dat_np(adn),
    .adv_hdr_cpl(ahc), .adv_dat_cpl(adc), .req(req),
    .dcost_p(cp), .dcost_np(cn), .dcost_cpl(cc), .np_done(np_done),
    .gnt(gnt), .np_outstanding(outst));

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cost(input int i);
    return i == 0 ? int'(cp) : i == 1 ? int'(cn) : int'(cc);
  endfunction
  function automatic int advh(input int i);
    return i == 0 ? int'(ahp) : i == 1 ? int'(ahn) : int'(ahc);
  endfunction
  function automatic int advd(input int i);
    return i == 0 ? int'(adp) : i == 1 ? int'(adn) : int'(adc);
  endfunction

  function automatic logic [2:0] expg();
    bit ok[3];
    for (int i = 0; i < 3; i++) begin
      bit hok;
      hok = mah[i] >= 1 + (mgh[i] ? 64 : 0);
      if (i == 1 && cnt_mode) hok = mout < minit;
      ok[i] = req[i] && hok && (mad[i] >= cost(i) + (mgd[i] ? 128 : 0));
    end
    return ok[2] ? 3'b100 : ok[0] ? 3'b001 : ok[1] ? 3'b010 : 3'b000;
  endfunction

  task automatic step();
    logic [2:0] e;
    bit up, dn;
    #1;
    e = expg();
    lastg = gnt;
    chk(int'(gnt), int'(e), "R7 R9 R3 R4 R5 grant");
    chk(int'(outst), mout, "R6 outstanding");
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      if (adv_upd) begin
        mah[i] = advh(i) - (e[i] ? 1 : 0); if (mah[i] < 0) mah[i] = 0;
        mad[i] = advd(i) - (e[i] ? cost(i) : 0); if (mad[i] < 0) mad[i] = 0;
        mgh[i] = advh(i) >= 128;
        mgd[i] = advd(i) >= 128;
      end else if (e[i]) begin
        mah[i] = mah[i] > 0 ? mah[i] - 1 : 0;
        mad[i] = mad[i] >= cost(i) ? mad[i] - cost(i) : 0;
      end
    end
    if (adv_upd) minit = int'(ahn);
    up = e[1] && mout != 255;
    dn = np_done && mout != 0;
    if (up && !dn) mout++;
    else if (dn && !up) mout--;
    @(negedge clk);
  endtask

  task automatic do_reset(input bit m);
    rst_n = 0; cnt_mode = m; adv_upd = 0; req = 0; np_done = 0;
    for (int i = 0; i < 3; i++) begin mah[i] = 0; mad[i] = 0; mgh[i] = 0; mgd[i] = 0; end
    minit = 0; mout = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic load(input int hp, dp, hn, dn_, hc, dcv);
    ahp = 8'(hp); adp = 12'(dp); ahn = 8'(hn); adn = 12'(dn_); ahc = 8'(hc); adc = 12'(dcv);
    adv_upd = 1; req = 0; step(); adv_upd = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset(0);
    req = 3'b111; #1;
    chk(int'(gnt), 0, "R1 no grant after reset");
    chk(int'(outst), 0, "R1 outstanding zero");
    step(); req = 0;

    load(129, 300, 0, 0, 0, 0);
    ng = 0; req = 3'b001; cp = 1;
    for (int k = 0; k < 80; k++) begin step(); if (lastg[0]) ng++; end
    chk(ng, 65, "R3 guarded header grants");

    load(0, 0, 0, 0, 10, 20);
    ng = 0; req = 3'b100; cc = 3;
    for (int k = 0; k < 20; k++) begin step(); if (lastg[2]) ng++; end
    chk(ng, 6, "R4 unguarded data grants");

    cc = 0; ahc = 50; adc = 40; adv_upd = 1; req = 3'b100;
    step(); adv_upd = 0;
    chk(int'(lastg), 3'b100, "R8 grant during update");
    ng = 0;
    for (int k = 0; k < 60; k++) begin step(); if (lastg[2]) ng++; end
    chk(ng, 49, "R8 R2 loaded minus coincident grant");

    load(200, 300, 200, 300, 200, 300);
    cp = 0; cn = 0; cc = 0;
    req = 3'b111; #1; chk(int'(gnt), 3'b100, "R7 completion first"); step();
    req = 3'b011; #1; chk(int'(gnt), 3'b001, "R7 posted over non-posted"); step();
    req = 3'b010; #1; chk(int'(gnt), 3'b010, "R7 non-posted alone"); step();
    req = 0; np_done = 1; step(); step(); np_done = 0; #1;
    chk(int'(outst), 0, "R6 saturates at zero");

    do_reset(1);
    load(0, 0, 3, 100, 0, 0);
    ng = 0; req = 3'b010; cn = 0;
    for (int k = 0; k < 10; k++) begin step(); if (lastg[1]) ng++; end
    chk(ng, 3, "R5 count limit");
    np_done = 1; req = 0; step(); np_done = 0;
    req = 3'b010; step();
    chk(int'(lastg), 3'b010, "R5 header pool bypassed");
    np_done = 1; step(); step(); np_done = 0; #1;
    chk(int'(outst), 2, "R6 grant and done hold");
    req = 0;

    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      for (int k = 0; k < 4000; k++) begin
        adv_upd = ($urandom_range(0, 5) == 0);
        ahp = 8'($urandom_range(0, 255)); ahn = 8'($urandom_range(0, 255)); ahc = 8'($urandom_range(0, 255));
        adp = 12'($urandom_range(0, 600)); adn = 12'($urandom_range(0, 600)); adc = 12'($urandom_range(0, 600));
        req = 3'($urandom_range(0, 7));
        cp = 9'($urandom_range(0, 20)); cn = 9'($urandom_range(0, 20)); cc = 9'($urandom_range(0, 20));
        np_done = ($urandom_range(0, 3) == 0);
        step();
      end
    end

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule